// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit keeps one private countdown timer for each hardware thread of a thread-interleaved processor and decides, for every decoded deadline instruction, what the pipeline does with it. A blocking deadline instruction holds its thread while that thread's timer is still nonzero. The pipeline replays the same instruction on the thread's next turn. Once the timer has drained to zero, the instruction retires and reloads the timer with its new deadline. The new deadline is taken either from the immediate field or from a register operand.

A branching variant never holds its thread. It always retires and reloads the timer. If the previous deadline had already run out by the time it executes, it also raises a missed-deadline flag, and the exception logic acts on that flag. Each thread's timer counts down by one on every pipeline iteration of that thread, which is signalled by a tick strobe with a thread ID. The timer stops at zero.

The stall, retire and miss outputs are a combinational function of the instruction inputs and the registered timer of the addressed thread. Timer updates take effect at the next clock edge.

Top module: `dtu_top`

## Requirements
- R1: After reset every timer reads zero, so the first blocking deadline instruction on any thread retires at once without a stall.
- R2: A blocking deadline instruction (kind 2'b00 or 2'b01) whose thread timer is nonzero asserts stall and does not assert retire. The timer is not reloaded, and it changes only through a tick.
- R3: A blocking deadline instruction whose thread timer is zero asserts retire, does not assert stall, and loads that timer with the new deadline at the next clock edge.
- R4: Kind 2'b00 takes the new deadline from imm_val. Kind 2'b01 takes it from reg_val.
- R5: A tick (tick_valid high) lowers the timer of thread tick_tid by exactly one at the clock edge and leaves every other thread's timer unchanged.
- R6: A tick on a timer that already reads zero leaves it at zero. The timer never wraps.
- R7: If a reload and a tick hit the same thread in the same cycle, the timer takes the reloaded value and the tick is discarded.
- R8: A branching deadline instruction (kind 2'b10) never asserts stall, always asserts retire, and loads imm_val into its thread timer.
- R9: A branching deadline instruction asserts miss_exc exactly when its thread timer reads zero as it executes.
- R10: While ins_valid is low, ins_kind is 2'b11, or ins_tid is not below the thread count, stall, retire and miss_exc all stay low and no timer is reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_valid | input | 1 | One pipeline iteration of thread tick_tid has occurred |
| tick_tid | input | 3 | Thread whose timer counts down |
| ins_valid | input | 1 | A decoded deadline instruction is present |
| ins_tid | input | 3 | Thread issuing the instruction |
| ins_kind | input | 2 | 00 immediate, 01 register, 10 branching, 11 none |
| imm_val | input | 32 | Immediate deadline value |
| reg_val | input | 32 | Register operand deadline value |
| stall | output | 1 | Hold the thread and replay the instruction |
| retire | output | 1 | The instruction completes and its timer is reloaded |
| miss_exc | output | 1 | A branching instruction found its deadline already expired |

## Verification
A thread's own tick and its own deadline reload can land in the same cycle, and the reload has to win. The bench provokes this by issuing instructions on a thread whose timer is zero while ticking that same thread in the same cycle. It then counts how many replays the next blocking instruction needs. A reload that lost to the tick would show one stall too few, and a wrap below zero would show a stall that never ends. Randomized traffic with small deadlines and frequent same-thread ticks produces this collision often. A bench model, in which the tick is applied first and the reload overwrites it, judges every cycle's stall, retire and miss outputs.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
package dtu_pkg;
  typedef enum logic [1:0] {
    DK_IMM    = 2'b00,
    DK_REG    = 2'b01,
    DK_BRANCH = 2'b10,
    DK_NONE   = 2'b11
  } dl_kind_e;

  function automatic logic kind_blocks(input logic [1:0] k);
    return (k == DK_IMM) || (k == DK_REG);
  endfunction

  function automatic logic kind_branches(input logic [1:0] k);
    return k == DK_BRANCH;
  endfunction
endpackage

// File: rtl/dtu_timer_slot.sv
`timescale 1ns/1ps
module dtu_timer_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] sat_dec(input logic [W-1:0] v);
    return (v == '0) ? '0 : v - W'(1);
  endfunction

  function automatic logic [W-1:0] next_cnt(input logic [W-1:0] v, input logic d,
                                            input logic l, input logic [W-1:0] nv);
    if (l)      return nv;
    else if (d) return sat_dec(v);
    else        return v;
  endfunction

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, dec_en, load_en, load_val);
  end

  assign cnt = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !load_en) |=> $stable(cnt_q)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R5
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en && cnt_q == '0) |=> (cnt_q == '0)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == $past(load_val))); // R7
endmodule

// File: rtl/dtu_timer_bank.sv
`timescale 1ns/1ps
module dtu_timer_bank #(
  parameter int N = 6,
  parameter int W = 32,
  localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_valid,
  input  logic [TID_W-1:0] tick_tid,
  input  logic             load_en,
  input  logic [TID_W-1:0] load_tid,
  input  logic [W-1:0]     load_val,
  input  logic [TID_W-1:0] rd_tid,
  output logic [W-1:0]     rd_cnt
);
  logic [W-1:0] cnt_w [N];
  logic [N-1:0] dec_sel;
  logic [N-1:0] load_sel;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign dec_sel[i]  = tick_valid && (tick_tid == TID_W'(i));
    assign load_sel[i] = load_en && (load_tid == TID_W'(i));
    dtu_timer_slot #(.W(W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec_en   (dec_sel[i]),
      .load_en  (load_sel[i]),
      .load_val (load_val),
      .cnt      (cnt_w[i])
    );
  end

  always_comb begin
    rd_cnt = '0;
    for (int k = 0; k < N; k++) begin
      if (rd_tid == TID_W'(k)) rd_cnt = cnt_w[k];
    end
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_sel)); // R3
  AST_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_sel)); // R5
endmodule

// File: rtl/dtu_issue.sv
`timescale 1ns/1ps
module dtu_issue #(
  parameter int W = 32
) (
  input  logic         ins_hit,
  input  logic [1:0]   ins_kind,
  input  logic [W-1:0] cur_cnt,
  input  logic [W-1:0] imm_val,
  input  logic [W-1:0] reg_val,
  output logic         stall,
  output logic         retire,
  output logic         miss_exc,
  output logic         load_en,
  output logic [W-1:0] load_val
);
  import dtu_pkg::*;

  logic is_block;
  logic is_branch;
  logic expired;

  always_comb begin
    is_block  = ins_hit && kind_blocks(ins_kind);
    is_branch = ins_hit && kind_branches(ins_kind);
    expired   = (cur_cnt == '0);
    stall     = is_block && !expired;
    retire    = (is_block && expired) || is_branch;
    miss_exc  = is_branch && expired;
    load_en   = retire;
    load_val  = (ins_kind == DK_REG) ? reg_val : imm_val;
  end
endmodule

// File: rtl/dtu_top.sv
`timescale 1ns/1ps
module dtu_top #(
  parameter int N = 6,
  parameter int W = 32,
  localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_valid,
  input  logic [TID_W-1:0] tick_tid,
  input  logic             ins_valid,
  input  logic [TID_W-1:0] ins_tid,
  input  logic [1:0]       ins_kind,
  input  logic [W-1:0]     imm_val,
  input  logic [W-1:0]     reg_val,
  output logic             stall,
  output logic             retire,
  output logic             miss_exc
);
  import dtu_pkg::*;

  logic         ins_hit;
  logic [W-1:0] cur_cnt;
  logic         load_en;
  logic [W-1:0] load_val;

  assign ins_hit = ins_valid && (32'(ins_tid) < N);

  dtu_timer_bank #(.N(N), .W(W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_valid (tick_valid),
    .tick_tid   (tick_tid),
    .load_en    (load_en),
    .load_tid   (ins_tid),
    .load_val   (load_val),
    .rd_tid     (ins_tid),
    .rd_cnt     (cur_cnt)
  );

  dtu_issue #(.W(W)) u_issue (
    .ins_hit  (ins_hit),
    .ins_kind (ins_kind),
    .cur_cnt  (cur_cnt),
    .imm_val  (imm_val),
    .reg_val  (reg_val),
    .stall    (stall),
    .retire   (retire),
    .miss_exc (miss_exc),
    .load_en  (load_en),
    .load_val (load_val)
  );

  AST_STALL_XOR_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !retire); // R2
  AST_BRANCH_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_hit && ins_kind == DK_BRANCH) |-> (retire && !stall)); // R8
  AST_MISS_ONLY_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    miss_exc |-> (retire && ins_kind == DK_BRANCH)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> !(stall || retire || miss_exc)); // R10
endmodule

// File: tb/sim_dtu_top.sv
`timescale 1ns/1ps
module sim_dtu_top;
  localparam int N = 6;
  localparam int W = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_valid = 1'b0;
  logic [2:0] tick_tid = '0;
  logic       ins_valid = 1'b0;
  logic [2:0] ins_tid = '0;
  logic [1:0] ins_kind = 2'b11;
  logic [W-1:0] imm_val = '0;
  logic [W-1:0] reg_val = '0;
  logic stall, retire, miss_exc;

  int total = 0;
  int bad = 0;
  int unsigned mt [N];
  int stall_seen;
  int seed;

  always #2.5 clk = ~clk;

  dtu_top #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_valid(tick_valid), .tick_tid(tick_tid),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_kind(ins_kind),
    .imm_val(imm_val), .reg_val(reg_val),
    .stall(stall), .retire(retire), .miss_exc(miss_exc));

  function automatic logic live(input int iv, input int tid, input int kind);
    return (iv != 0) && (tid < N) && (kind != 3);
  endfunction

  function automatic logic [2:0] expect_out(input int iv, input int tid, input int kind,
                                            input int unsigned cur);
    logic s, r, e;
    s = 1'b0; r = 1'b0; e = 1'b0;
    if (live(iv, tid, kind)) begin
      if (kind == 2) begin
        r = 1'b1;
        e = (cur == 0);
      end else if (cur == 0) r = 1'b1;
      else s = 1'b1;
    end
    return {s, r, e};
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {stall,retire,miss} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input int iv, input int tid, input int kind,
                      input int unsigned imm, input int unsigned rv,
                      input int tv, input int ttid);
    logic [2:0] exp;
    int unsigned cur;
    @(negedge clk);
    ins_valid = (iv != 0); ins_tid = 3'(tid); ins_kind = 2'(kind);
    imm_val = imm; reg_val = rv;
    tick_valid = (tv != 0); tick_tid = 3'(ttid);
    #1;
    cur = (tid < N) ? mt[tid] : 0;
    exp = expect_out(iv, tid, kind, cur);
    check(tag, {stall, retire, miss_exc}, exp);
    if (stall) stall_seen++;
    @(posedge clk);
    if (tv != 0 && ttid < N && mt[ttid] != 0) mt[ttid] = mt[ttid] - 1;
    if (exp[1]) mt[tid] = (kind == 1) ? rv : imm;
  endtask

  task automatic count_check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: stall count actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed = 17;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) mt[i] = 0;
    #12 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10 reset idle", {stall, retire, miss_exc}, 3'b000);

    for (int t = 0; t < N; t++) step("R1 first deadline", 1, t, 0, 0, 0, 0, 0);

    // R4: register variant uses reg_val (3), not imm_val (50)
    step("R4 reg load", 1, 0, 1, 50, 3, 0, 0);
    stall_seen = 0;
    for (int k = 0; k < 3; k++) step("R2 R5 drain", 1, 0, 0, 0, 0, 1, 0);
    step("R3 retire at zero", 1, 0, 0, 0, 0, 0, 0);
    count_check("R4 R5 replay count", stall_seen, 3);

    // R6: saturate at zero then branch sees expiry
    for (int k = 0; k < 4; k++) step("R6 floor tick", 0, 0, 0, 0, 0, 1, 1);
    step("R6 R9 miss after floor", 1, 1, 2, 0, 0, 0, 0);

    // R7: reload and tick collide on thread 2
    step("R7 collide", 1, 2, 0, 2, 0, 1, 2);
    stall_seen = 0;
    for (int k = 0; k < 2; k++) step("R7 drain", 1, 2, 0, 0, 0, 1, 2);
    step("R7 retire", 1, 2, 0, 0, 0, 0, 0);
    count_check("R7 reload wins", stall_seen, 2);

    // R8/R9: branch on busy timer
    step("R8 arm", 1, 3, 0, 5, 0, 0, 0);
    step("R8 branch busy no miss", 1, 3, 2, 1, 0, 0, 0);
    step("R8 reload visible stall", 1, 3, 0, 0, 0, 1, 3);
    step("R8 reload drained", 1, 3, 0, 0, 0, 0, 0);

    // R10: ignored instructions leave timer state untouched
    step("R10 arm", 1, 4, 0, 2, 0, 0, 0);
    step("R10 valid low", 0, 4, 0, 9, 0, 0, 0);
    step("R10 kind none", 1, 4, 3, 9, 0, 0, 0);
    step("R10 tid out of range", 1, 7, 0, 9, 0, 0, 0);
    step("R10 still stalled", 1, 4, 0, 0, 0, 1, 4);
    step("R10 one left", 1, 4, 0, 0, 0, 1, 4);
    step("R10 timer kept", 1, 4, 0, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      int iv, tid, kind, tv, ttid;
      iv = ($urandom % 4) != 0;
      tid = $urandom % 8;
      kind = $urandom % 4;
      tv = ($urandom % 10) < 7;
      ttid = (($urandom % 3) == 0) ? tid : $urandom % 8;
      step("R2 R3 R5 R7 R9 random", iv, tid, kind, $urandom % 5, $urandom % 5, tv, ttid);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule